// File: doc/BRIEF.md
# I2C Master Interrupt Event Unit

This block collects the event flags reported by an I2C master's protocol engine and turns them into one level-sensitive interrupt line for the host. The engine signals four kinds of event as single-cycle pulses: transaction done, ACK error, high-speed NACK error and restart point. Each event sets a sticky status flag. The host clears a flag by writing a 1 to its bit position, so writing back a value just read clears exactly the events that were seen.

A mask register with the same bit layout selects which flags may raise the interrupt. The interrupt is a registered OR of the enabled flags. An ACK error arrives as two events in order: the error flag first, then the done flag. Both stay visible until the host clears them.

A third register carries the command bits. When the host writes it, the block sends single-cycle pulses to the engine for transaction start, the multi-trigger used in auto-restart sequences, and the multi-message restart configuration. A synchronous soft clear returns all state to idle.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset, status, mask, interrupt and all command pulses are 0.
- R2: An event pulse sets its status flag at the next clock edge, at bit 0 (done), bit 1 (ACK error), bit 2 (high-speed NACK) or bit 4 (restart point). The flag stays set until it is cleared.
- R3: A write to the status register (address 0) clears every implemented flag whose data bit is 1. Bits written as 0, and unimplemented bits, have no effect.
- R4: If an event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: An ACK error event followed by a later done event leaves both bit 1 and bit 0 set together.
- R6: The mask register (address 1) stores bits 0, 1, 2 and 4, with the same meaning as the status bits. Other bits read as 0.
- R7: The interrupt output is high, one cycle after the flags and mask change, exactly when some status bit and its mask bit are both 1. A flag whose mask bit is 0 never raises it.
- R8: A write to the start register (address 2) sends a one-cycle pulse in the following cycle: start_pulse from data bit 0, mtrig_pulse from bit 14 and mcfg_pulse from bit 15. The register always reads as 0.
- R9: Soft clear, one cycle long, clears status, mask, interrupt and any command pulse due in the next cycle. It wins over events and writes in the same cycle.
- R10: Address 3 reads as 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of all state |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ev_done | input | 1 | Event pulse: transaction complete |
| ev_ackerr | input | 1 | Event pulse: ACK error |
| ev_hsnack | input | 1 | Event pulse: high-speed NACK error |
| ev_rstpt | input | 1 | Event pulse: restart point reached |
| irq | output | 1 | Interrupt to host, active high |
| start_pulse | output | 1 | Pulse to engine: begin transaction |
| mtrig_pulse | output | 1 | Pulse to engine: auto-restart multi-trigger |
| mcfg_pulse | output | 1 | Pulse to engine: multi-message restart configuration |

## Verification
Two functions can fall in the same cycle: an engine event can set a flag while the host's write-1 clears that same flag. A soft clear can also coincide with an event or with a start write. The bench raises the event pulse and the status write on the same clock edge. It then reads the status port and expects the flag still set, while flags cleared without a competing event must read 0. For the soft clear, it expects status, mask, interrupt and the command pulse all to read 0 afterwards.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int DATA_W     = 16;
  localparam int POS_DONE   = 0;
  localparam int POS_ACKERR = 1;
  localparam int POS_HSNACK = 2;
  localparam int POS_RSTPT  = 4;
  localparam int POS_GO     = 0;
  localparam int POS_MTRIG  = 14;
  localparam int POS_MCFG   = 15;

  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << POS_DONE) | (DATA_W'(1) << POS_ACKERR) |
    (DATA_W'(1) << POS_HSNACK) | (DATA_W'(1) << POS_RSTPT);

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_MASK   = 2'd1,
    RA_START  = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;

  // next flag value: set beats clear, soft clear beats both
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr, input logic wipe);
    if (wipe)      return 1'b0;
    else if (set)  return 1'b1;
    else if (clr)  return 1'b0;
    else           return cur;
  endfunction

  function automatic logic irq_reduce(input logic [DATA_W-1:0] sts,
                                      input logic [DATA_W-1:0] msk);
    return |(sts & msk & IMPL_MASK);
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import i2c_irq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter logic [W-1:0] IMPL = IMPL_MASK[W-1:0]
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_ff
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= flag_next(q, set_vec[i], clr_vec[i], wipe);
      end
      assign flags[i] = q;
    end else begin : g_tie
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import i2c_irq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter logic [W-1:0] IMPL = IMPL_MASK[W-1:0]
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] mask
);
  logic [W-1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (wipe) q <= '0;
    else if (load) q <= din & IMPL;
  end
  assign mask = q;
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import i2c_irq_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] mask,
  output logic         irq
);
  logic q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (wipe) q <= 1'b0;
    else           q <= irq_reduce(flags, mask);
  end
  assign irq = q;
endmodule

// File: rtl/cmd_pulse_gen.sv
module cmd_pulse_gen #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         load,
  input  logic [N-1:0] cmd,
  output logic [N-1:0] pulses
);
  logic [N-1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (wipe || !load)  q <= '0;
    else                     q <= cmd;
  end
  assign pulses = q;
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          ev_done,
  input  logic          ev_ackerr,
  input  logic          ev_hsnack,
  input  logic          ev_rstpt,
  output logic          irq,
  output logic          start_pulse,
  output logic          mtrig_pulse,
  output logic          mcfg_pulse
);
  localparam int NCMD = 3;

  // named internal events, also used by the checker
  logic          wr_status, wr_mask, wr_start;
  logic [W-1:0]  set_vec, clr_vec, sts_q, msk_q;
  logic [NCMD-1:0] cmd_bits, cmd_q;

  assign wr_status = bus_we && (bus_addr == AW'(RA_STATUS));
  assign wr_mask   = bus_we && (bus_addr == AW'(RA_MASK));
  assign wr_start  = bus_we && (bus_addr == AW'(RA_START));

  always_comb begin
    set_vec = '0;
    set_vec[POS_DONE]   = ev_done;
    set_vec[POS_ACKERR] = ev_ackerr;
    set_vec[POS_HSNACK] = ev_hsnack;
    set_vec[POS_RSTPT]  = ev_rstpt;
  end

  assign clr_vec  = wr_status ? bus_wdata : '0;
  assign cmd_bits = {bus_wdata[POS_MCFG], bus_wdata[POS_MTRIG], bus_wdata[POS_GO]};

  irq_flag_bank #(.W(W), .IMPL(IMPL_MASK[W-1:0])) u_flags (
    .clk(clk), .rst_n(rst_n), .wipe(soft_clr),
    .set_vec(set_vec), .clr_vec(clr_vec), .flags(sts_q)
  );

  irq_mask_reg #(.W(W), .IMPL(IMPL_MASK[W-1:0])) u_mask (
    .clk(clk), .rst_n(rst_n), .wipe(soft_clr),
    .load(wr_mask), .din(bus_wdata), .mask(msk_q)
  );

  irq_line_gen #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .wipe(soft_clr),
    .flags(sts_q), .mask(msk_q), .irq(irq)
  );

  cmd_pulse_gen #(.N(NCMD)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wipe(soft_clr),
    .load(wr_start), .cmd(cmd_bits), .pulses(cmd_q)
  );

  assign start_pulse = cmd_q[0];
  assign mtrig_pulse = cmd_q[1];
  assign mcfg_pulse  = cmd_q[2];

  always_comb begin
    case (bus_addr)
      AW'(RA_STATUS): bus_rdata = sts_q;
      AW'(RA_MASK):   bus_rdata = msk_q;
      default:        bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
#(
  parameter int W = DATA_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         soft_clr,
  input logic         wr_status,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] set_vec,
  input logic [W-1:0] sts_q,
  input logic [W-1:0] msk_q,
  input logic         irq,
  input logic         start_pulse,
  input logic         mtrig_pulse,
  input logic         mcfg_pulse
);
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[POS_DONE] && !soft_clr) |=> sts_q[POS_DONE]); // R4

  AST_ACKERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[POS_ACKERR] && !soft_clr && !(wr_status && bus_wdata[POS_ACKERR]))
      |=> sts_q[POS_ACKERR]); // R2

  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && bus_wdata[POS_DONE] && !set_vec[POS_DONE]) |=> !sts_q[POS_DONE]); // R3

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_clr |=> (irq == ($past(sts_q & msk_q) != '0))); // R7

  AST_SOFT_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (sts_q == '0 && msk_q == '0 && !irq &&
                  !start_pulse && !mtrig_pulse && !mcfg_pulse)); // R9

  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R8

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~IMPL_MASK[W-1:0]) == '0) && ((msk_q & ~IMPL_MASK[W-1:0]) == '0)); // R6
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_status(wr_status),
  .bus_wdata(bus_wdata), .set_vec(set_vec), .sts_q(sts_q), .msk_q(msk_q),
  .irq(irq), .start_pulse(start_pulse), .mtrig_pulse(mtrig_pulse),
  .mcfg_pulse(mcfg_pulse)
);

// File: tb/test_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module test_i2c_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_clr = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic ev_done = 0, ev_ackerr = 0, ev_hsnack = 0, ev_rstpt = 0;
  logic irq, start_pulse, mtrig_pulse, mcfg_pulse;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_irq_ctrl i_i2c_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_done(ev_done), .ev_ackerr(ev_ackerr), .ev_hsnack(ev_hsnack),
    .ev_rstpt(ev_rstpt), .irq(irq), .start_pulse(start_pulse),
    .mtrig_pulse(mtrig_pulse), .mcfg_pulse(mcfg_pulse)
  );

  // {events[3:0] = rstpt,hsnack,ackerr,done ; clear word ; expected status}
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {4'b0001, 16'h0000, 16'h0001},
    {4'b0010, 16'h0000, 16'h0003},
    {4'b0000, 16'h0001, 16'h0002},
    {4'b1100, 16'h0000, 16'h0016},
    {4'b0001, 16'h0001, 16'h0017},
    {4'b0000, 16'h0017, 16'h0000},
    {4'b1000, 16'hFFE0, 16'h0010},
    {4'b0000, 16'h0010, 16'h0000}
  };
  localparam logic [15:0] ALL_EN = 16'h0017;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_we = 0; soft_clr = 0;
    {ev_rstpt, ev_hsnack, ev_ackerr, ev_done} = 4'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #0.1; d = bus_rdata;
  endtask

  initial begin
    logic [15:0] r;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, r); check("R1 status", r, 16'h0);
    rd(2'd1, r); check("R1 mask", r, 16'h0);
    check("R1 irq/pulses", {12'h0, irq, start_pulse, mtrig_pulse, mcfg_pulse}, 16'h0);

    // R6 mask readback of implemented bits only
    wr(2'd1, 16'hFFFF);
    rd(2'd1, r); check("R6 mask readback", r, ALL_EN);

    // vector table: R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ev_rstpt, ev_hsnack, ev_ackerr, ev_done} = VEC[i][35:32];
      bus_addr = 2'd0; bus_wdata = VEC[i][31:16]; bus_we = (VEC[i][31:16] != 0);
      @(negedge clk); idle();
      rd(2'd0, r); check($sformatf("R2/R3/R4 vec%0d status", i), r, VEC[i][15:0]);
      @(negedge clk);
      check($sformatf("R7 vec%0d irq", i), {15'h0, irq}, {15'h0, |(VEC[i][15:0] & ALL_EN)});
    end

    // R5: ACK error then done on later cycle, both visible
    @(negedge clk); ev_ackerr = 1; @(negedge clk); idle();
    @(negedge clk); ev_done = 1;   @(negedge clk); idle();
    rd(2'd0, r); check("R5 ackerr+done together", r, 16'h0003);
    wr(2'd0, r);
    rd(2'd0, r); check("R3 write-back clears", r, 16'h0000);

    // R7 masked flag does not raise irq; latency of one cycle
    wr(2'd1, 16'h0002);
    @(negedge clk); ev_done = 1; @(negedge clk); idle();
    @(negedge clk); check("R7 masked done no irq", {15'h0, irq}, 16'h0);
    ev_ackerr = 1; @(negedge clk); idle();
    check("R7 irq not yet", {15'h0, irq}, 16'h0);
    @(negedge clk); check("R7 irq after one cycle", {15'h0, irq}, 16'h1);
    wr(2'd0, 16'h0003);
    @(negedge clk); check("R7 irq drops", {15'h0, irq}, 16'h0);

    // R8 start register pulses
    @(negedge clk); bus_we = 1; bus_addr = 2'd2; bus_wdata = 16'hC001;
    @(negedge clk); idle();
    check("R8 pulses high", {13'h0, start_pulse, mtrig_pulse, mcfg_pulse}, 16'h7);
    rd(2'd2, r); check("R8 start reads 0", r, 16'h0);
    @(negedge clk);
    check("R8 pulses one cycle", {13'h0, start_pulse, mtrig_pulse, mcfg_pulse}, 16'h0);
    wr(2'd2, 16'h4000);
    check("R8 trigger only", {13'h0, start_pulse, mtrig_pulse, mcfg_pulse}, 16'h2);

    // R10 address 3 ignored
    wr(2'd3, 16'hFFFF);
    rd(2'd3, r); check("R10 addr3 reads 0", r, 16'h0);
    rd(2'd1, r); check("R10 mask untouched", r, 16'h0002);
    rd(2'd0, r); check("R10 status untouched", r, 16'h0);

    // R9 soft clear wins over events and start write
    wr(2'd1, ALL_EN);
    @(negedge clk); ev_rstpt = 1; @(negedge clk); idle();
    @(negedge clk); check("R9 irq before clear", {15'h0, irq}, 16'h1);
    soft_clr = 1; ev_done = 1; bus_we = 1; bus_addr = 2'd2; bus_wdata = 16'h0001;
    @(negedge clk); idle();
    rd(2'd0, r); check("R9 status cleared", r, 16'h0);
    rd(2'd1, r); check("R9 mask cleared", r, 16'h0);
    check("R9 irq and pulse", {14'h0, irq, start_pulse}, 16'h0);

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin repeat (20000) @(posedge clk); n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule